// File: doc/BRIEF.md
# Crystal Reference Divider with Twin Three-State Phase Comparators

This block is the digital core of a two-loop frequency synthesizer. A counter divides the crystal clock (10.24 MHz in the intended use) by a fixed, even ratio, 2048 by default, which gives a 5 kHz comparison rate. The divided signal also leaves the block as a square wave that can serve as a guard tone.

The rising edge of that square wave is the reference event. It is compared against the rising edge of two divided-oscillator feedback inputs, one for the transmit loop and one for the receive loop. Each loop has its own phase-frequency comparator. Each comparator drives a three-state pump output, modelled as pump-up, pump-down and drive-enable, toward an external loop filter. When no correction is pending, the drive-enable is low and the pin floats.

An active-low standby input parks only the transmit comparator, to save power. The receive comparator keeps running through standby.

Top module: `refdiv_dual_pfd`

## Requirements
- R1: While `rst` is sampled high, the next clock edge leaves `ref_tone`, `tx_up`, `tx_dn`, `tx_oe`, `rx_up`, `rx_dn` and `rx_oe` all low.
- R2: After reset, `ref_tone` starts low and inverts every REF_DIV/2 clock edges, so it has a 50% duty cycle and a period of REF_DIV clocks. Its first inversion comes on the (REF_DIV/2)-th edge after reset is released.
- R3: The clock edge on which `ref_tone` goes from 0 to 1 is the reference event. On that edge, an enabled comparator that is idle raises its pump-up output. A comparator whose pump-up is already high keeps it high.
- R4: A feedback edge is the first clock edge that samples a feedback input high after it was sampled low on the previous edge. On that edge, an idle comparator raises pump-down. A feedback input that stays high does not make a second feedback edge.
- R5: A comparator with pump-up high returns to idle on its next feedback edge. A comparator with pump-down high returns to idle on the next reference event. A reference event and a feedback edge on the same clock edge leave an idle comparator idle.
- R6: Each drive-enable output is high exactly when its pump-up or pump-down output is high. Pump-up and pump-down of one loop are never high together.
- R7: While `standby_n` is sampled low, the transmit outputs are low from the next edge on and the transmit comparator is held idle. The receive comparator keeps working.
- R8: The two comparators act independently: a feedback edge on one loop does not change the outputs of the other.
- R9: A reset asserted during operation restarts the divider phase and returns both comparators to idle, just as the first reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| standby_n | input | 1 | Low parks the transmit comparator; high is normal operation |
| tx_fb | input | 1 | Divided transmit oscillator, synchronous to `clk` |
| rx_fb | input | 1 | Divided receive oscillator, synchronous to `clk` |
| ref_tone | output | 1 | Reference square wave (guard tone) |
| tx_up | output | 1 | Transmit pump drives high |
| tx_dn | output | 1 | Transmit pump drives low |
| tx_oe | output | 1 | Transmit pump enable; low means the pin floats |
| rx_up | output | 1 | Receive pump drives high |
| rx_dn | output | 1 | Receive pump drives low |
| rx_oe | output | 1 | Receive pump enable; low means the pin floats |

## Verification
The bench builds the block with REF_DIV = 16 instead of 2048. A reference event then comes every 16 clocks, so many reference periods fit in a short run. This lets the bench place a feedback edge a chosen number of clocks before, on, or after a reference event, which covers the leading, lagging and coincident cases (R3, R4, R5). It also makes it practical to enter and leave standby in the middle of a pump pulse, and to reset in the middle of a tone period. The tone's half period stays a power of two, so the wrap compare and the counter width are the same kind of structure as in the default build.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;

    localparam int NUM_LOOPS = 2;
    localparam int LOOP_TX   = 0;
    localparam int LOOP_RX   = 1;

    // Comparator condition: idle (pin floats), pumping up, pumping down
    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_UP   = 2'd1,
        PD_DN   = 2'd2
    } pd_state_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic oe;
    } pump_t;

    function automatic pump_t pump_of(pd_state_e s);
        pump_t p;
        p.up = (s == PD_UP);
        p.dn = (s == PD_DN);
        p.oe = (s != PD_IDLE);
        return p;
    endfunction

    function automatic int half_of(int div);
        return div / 2;
    endfunction

endpackage

// File: rtl/refpfd_divider.sv
module refpfd_divider
    import refpfd_pkg::*;
#(
    parameter int REF_DIV = 2048
) (
    input  logic clk,
    input  logic rst,
    output logic tone,
    output logic ref_evt
);

    localparam int HALF = half_of(REF_DIV);
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap    = (cnt == LAST);
    // reference event: the edge on which the tone goes from low to high
    assign ref_evt = wrap & ~tone;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tone <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            tone <= ~tone;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector
    import refpfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  ref_evt,
    input  logic  fb,
    output pump_t pump
);

    pd_state_e state, state_nx;
    logic      fb_q;
    logic      fb_evt;

    assign fb_evt = fb & ~fb_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            PD_IDLE: begin
                if (ref_evt && !fb_evt)      state_nx = PD_UP;
                else if (fb_evt && !ref_evt) state_nx = PD_DN;
            end
            PD_UP:   if (fb_evt)  state_nx = PD_IDLE;
            PD_DN:   if (ref_evt) state_nx = PD_IDLE;
            default: state_nx = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q  <= 1'b0;
            state <= PD_IDLE;
        end else begin
            fb_q  <= fb;
            state <= en ? state_nx : PD_IDLE;
        end
    end

    assign pump = pump_of(state);

endmodule

// File: rtl/refdiv_dual_pfd.sv
module refdiv_dual_pfd
    import refpfd_pkg::*;
#(
    parameter int REF_DIV = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic standby_n,
    input  logic tx_fb,
    input  logic rx_fb,
    output logic ref_tone,
    output logic tx_up,
    output logic tx_dn,
    output logic tx_oe,
    output logic rx_up,
    output logic rx_dn,
    output logic rx_oe
);

    logic                 ref_evt;
    logic [NUM_LOOPS-1:0] loop_en;
    logic [NUM_LOOPS-1:0] loop_fb;
    pump_t                pumps [NUM_LOOPS];

    refpfd_divider #(.REF_DIV(REF_DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tone    (ref_tone),
        .ref_evt (ref_evt)
    );

    assign loop_en[LOOP_TX] = standby_n;
    assign loop_en[LOOP_RX] = 1'b1;
    assign loop_fb[LOOP_TX] = tx_fb;
    assign loop_fb[LOOP_RX] = rx_fb;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        refpfd_detector u_det (
            .clk     (clk),
            .rst     (rst),
            .en      (loop_en[g]),
            .ref_evt (ref_evt),
            .fb      (loop_fb[g]),
            .pump    (pumps[g])
        );
    end

    assign tx_up = pumps[LOOP_TX].up;
    assign tx_dn = pumps[LOOP_TX].dn;
    assign tx_oe = pumps[LOOP_TX].oe;
    assign rx_up = pumps[LOOP_RX].up;
    assign rx_dn = pumps[LOOP_RX].dn;
    assign rx_oe = pumps[LOOP_RX].oe;

endmodule

// File: rtl/refdiv_dual_pfd_chk.sv
module refdiv_dual_pfd_chk #(
    parameter int REF_DIV = 2048
) (
    input logic clk,
    input logic rst,
    input logic standby_n,
    input logic tx_fb,
    input logic rx_fb,
    input logic ref_tone,
    input logic tx_up,
    input logic tx_dn,
    input logic rx_up,
    input logic rx_dn
);

    localparam int HALF = REF_DIV / 2;

    // edges since the tone last changed, counted by the checker itself
    int   gap;
    logic tone_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= -1;
            tone_prev <= 1'b0;
        end else begin
            tone_prev <= ref_tone;
            gap       <= (ref_tone != tone_prev) ? 0 : gap + 1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ref_tone && !tx_up && !tx_dn && !rx_up && !rx_dn)); // R1

    AST_TONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        ((ref_tone != tone_prev) == (gap == HALF - 1))); // R2

    AST_TX_UP_ON_REF: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_up) |-> $rose(ref_tone)); // R3

    AST_RX_UP_ON_REF: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_up) |-> $rose(ref_tone)); // R3

    AST_TX_DN_ON_FB: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_dn) |-> $past(tx_fb)); // R4

    AST_RX_DN_ON_FB: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_dn) |-> $past(rx_fb)); // R4

    AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(tx_up && tx_dn) && !(rx_up && rx_dn)); // R6

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        !standby_n |=> (!tx_up && !tx_dn)); // R7

endmodule

bind refdiv_dual_pfd refdiv_dual_pfd_chk #(.REF_DIV(REF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .standby_n (standby_n),
    .tx_fb     (tx_fb),
    .rx_fb     (rx_fb),
    .ref_tone  (ref_tone),
    .tx_up     (tx_up),
    .tx_dn     (tx_dn),
    .rx_up     (rx_up),
    .rx_dn     (rx_dn)
);

// File: tb/refdiv_dual_pfd_tb.sv
module refdiv_dual_pfd_tb;

    localparam int REF_DIV = 16;
    localparam int HALF    = REF_DIV / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby_n = 1'b1;
    logic tx_fb = 1'b0;
    logic rx_fb = 1'b0;
    logic ref_tone, tx_up, tx_dn, tx_oe, rx_up, rx_dn, rx_oe;

    always #10 clk = ~clk;   // 50 MHz

    refdiv_dual_pfd #(.REF_DIV(REF_DIV)) u_dut (
        .clk(clk), .rst(rst), .standby_n(standby_n),
        .tx_fb(tx_fb), .rx_fb(rx_fb), .ref_tone(ref_tone),
        .tx_up(tx_up), .tx_dn(tx_dn), .tx_oe(tx_oe),
        .rx_up(rx_up), .rx_dn(rx_dn), .rx_oe(rx_oe)
    );

    typedef struct {
        string tag;
        bit    tone, tu, td, ru, rd;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    int   k = 0;                 // edges since reset release
    bit   mtu, mtd, mru, mrd;    // expected pump levels
    bit   ptx, prx;              // feedback level sampled on the previous edge

    task automatic chk(string tag, string what, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // R5: a pending pulse ends on the opposite event; both together give nothing
    task automatic adv(inout bit u, inout bit d, input bit re, input bit fe);
        u = u | re;
        d = d | fe;
        if (u && d) begin
            u = 1'b0;
            d = 1'b0;
        end
    endtask

    function automatic bit is_ref(int m);
        return (m > 0) && (m % HALF == 0) && ((m / HALF) % 2 == 1);
    endfunction

    // driver: one clock per call, pushes what the outputs must show after the edge
    task automatic step(bit r, bit sb, bit tf, bit rf, string tag);
        exp_t e;
        bit   re;
        @(negedge clk);
        #2;
        rst = r; standby_n = sb; tx_fb = tf; rx_fb = rf;
        if (r) begin
            k = 0; mtu = 0; mtd = 0; mru = 0; mrd = 0; ptx = 0; prx = 0;
        end else begin
            k++;
            re = is_ref(k);
            if (!sb) begin
                mtu = 0; mtd = 0;
            end else begin
                adv(mtu, mtd, re, tf & ~ptx);
            end
            adv(mru, mrd, re, rf & ~prx);
            ptx = tf; prx = rf;
        end
        e.tag  = tag;
        e.tone = r ? 1'b0 : ((k / HALF) % 2 == 1);
        e.tu = mtu; e.td = mtd; e.ru = mru; e.rd = mrd;
        q.push_back(e);
    endtask

    task automatic run(int n, bit sb, bit tf, bit rf, string tag);
        for (int i = 0; i < n; i++) step(1'b0, sb, tf, rf, tag);
    endtask

    // idle until the next reference event is n edges away
    task automatic go_before(int n);
        while (!is_ref(k + n)) step(1'b0, standby_n, 1'b0, 1'b0, "R2");
    endtask

    // monitor: pops one expectation per cycle, away from the active edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                chk("R2", "ref_tone", ref_tone, e.tone);
                chk(e.tag, "tx_up", tx_up, e.tu);
                chk(e.tag, "tx_dn", tx_dn, e.td);
                chk(e.tag, "rx_up", rx_up, e.ru);
                chk(e.tag, "rx_dn", rx_dn, e.rd);
                chk("R6", "tx_oe", tx_oe, e.tu | e.td);
                chk("R6", "rx_oe", rx_oe, e.ru | e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R1");
        // R2, R3: free run without feedback, pump-up raised at the first tone rise and held
        run(30, 1'b1, 1'b0, 1'b0, "R3");
        // R5, R8: lagging transmit feedback ends only the transmit pulse
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
        run(3, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R8");
        run(2, 1'b1, 1'b0, 1'b0, "R8");
        // R4 then R5: feedback four edges ahead of the reference
        go_before(4);
        step(1'b0, 1'b1, 1'b1, 1'b1, "R4");
        run(2, 1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R5");
        run(3, 1'b1, 1'b0, 1'b0, "R5");
        // R5: feedback edge coincident with the reference event
        go_before(1);
        step(1'b0, 1'b1, 1'b1, 1'b1, "R5");
        run(5, 1'b1, 1'b0, 1'b0, "R5");
        // R4: feedback held high gives only one edge
        go_before(6);
        run(24, 1'b1, 1'b1, 1'b1, "R4");
        run(2, 1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b1, "R5");
        run(2, 1'b1, 1'b0, 1'b0, "R5");
        // R7: standby entered while the transmit pump is up
        go_before(1);
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 8; i++) begin
            run(3, 1'b0, 1'b1, i[0], "R7");
            run(2, 1'b0, 1'b0, 1'b0, "R7");
        end
        // R8: leave standby, different patterns on each loop
        for (int i = 0; i < 6; i++) begin
            run(5, 1'b1, 1'b1, 1'b0, "R8");
            run(4, 1'b1, 1'b0, 1'b1, "R8");
            run(3, 1'b1, 1'b0, 1'b0, "R8");
        end
        // R9: reset in the middle of a pump pulse and a tone period
        go_before(1);
        step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
        run(3, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R9");
        run(20, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R9");
        run(4, 1'b1, 1'b0, 1'b0, "R9");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule